// File: doc/BRIEF.md
# Loopback Mode Control Unit

This unit chooses the diagnostic loopback path of a half-duplex Ethernet-style controller. Software writes a 2-bit loopback selector and a receive-CRC-check bit through a configuration write strobe. The unit then steers the serial data and receive clock between the local serializer, the local deserializer and the line. It drives a control output that makes an external serial interface device loop its signals back. It also decides which carrier-sense and collision indications reach the status path.

Raw carrier-sense and collision inputs pass through a two-flop synchronizer. The deferral outputs always carry the synchronized values. The status outputs carry those values after masking, and the masking depends on the active mode. A nonzero mode cannot be switched straight to a different nonzero mode. Such a write is discarded and raises a sticky error flag. Software clears the flag with a dedicated strobe.

Top module: `lbk_ctrl`

## Requirements
- R1: After reset the mode is 00 (normal). `phy_loop_force`, `mode_err`, `rx_addr_chk_en`, `rx_crc_chk_en` and all synchronized status and deferral outputs are 0.
- R2: In mode 01 (internal loopback), `deser_rx_data` equals `ser_tx_data`, `deser_rx_clk` follows `tx_clk_in`, and `line_tx_data` is held at 0.
- R3: In mode 10 (external-interface loopback), `phy_loop_force` is 1 and `line_tx_data` follows `ser_tx_data`. In every other mode `phy_loop_force` is 0.
- R4: In modes 00, 10 and 11, `line_tx_data` follows `ser_tx_data`, `deser_rx_data` follows `line_rx_data`, and `deser_rx_clk` follows `line_rx_clk`.
- R5: In mode 01, `status_crs` and `status_col` are 0 whatever the inputs are, while `defer_crs` and `defer_col` still report the synchronized inputs.
- R6: In mode 10, `status_col` is 0 and `status_crs` reports the synchronized carrier. In modes 00 and 11, both status outputs report the synchronized inputs.
- R7: A change on `crs_raw` or `col_raw` reaches the deferral and status outputs on the second rising clock edge after it is applied.
- R8: A write with `cfg_wr` high whose selector is nonzero, while the current mode is nonzero and different from it, leaves the mode and the CRC-check bit unchanged and sets `mode_err` on the next edge.
- R9: `mode_err` stays set until `err_clear` is pulsed. If an illegal write and `err_clear` occur in the same cycle, the flag ends up set.
- R10: A legal write is one to 00, one made from mode 00, or one that rewrites the same mode. It updates `lb_mode` and every mode-dependent output on the clock edge that samples the write.
- R11: `rx_addr_chk_en` is 1 in any nonzero mode. `rx_crc_chk_en` is 1 only in a nonzero mode whose accepted write had `cfg_crc_chk` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_loop_sel | input | 2 | Requested loopback mode: 00 normal, 01 internal, 10 external interface, 11 line |
| cfg_crc_chk | input | 1 | Requested receive CRC check during loopback |
| err_clear | input | 1 | Clears the sticky mode-change error flag |
| ser_tx_data | input | DATA_W | Serializer output |
| tx_clk_in | input | 1 | Transmit clock, sampled as a level |
| line_rx_data | input | DATA_W | Receive data from the serial interface |
| line_rx_clk | input | 1 | Receive clock recovered by the serial interface |
| crs_raw | input | 1 | Asynchronous carrier sense |
| col_raw | input | 1 | Asynchronous collision |
| lb_mode | output | 2 | Active loopback mode |
| phy_loop_force | output | 1 | Commands the serial interface device to loop back |
| line_tx_data | output | DATA_W | Transmit data toward the serial interface |
| deser_rx_data | output | DATA_W | Data into the deserializer |
| deser_rx_clk | output | 1 | Clock into the deserializer |
| status_crs | output | 1 | Carrier sense as seen by the status path |
| status_col | output | 1 | Collision as seen by the status path |
| defer_crs | output | 1 | Synchronized carrier sense for transmit deferral |
| defer_col | output | 1 | Synchronized collision for transmit deferral |
| rx_addr_chk_en | output | 1 | Receiver destination-address matching enabled for loopback |
| rx_crc_chk_en | output | 1 | Receiver CRC check enabled for loopback |
| mode_err | output | 1 | Sticky illegal mode-change flag |

## Verification
The hardest situation to reach is an illegal direct change that arrives in the same cycle as an error clear, or a rewrite of the current nonzero mode, which must be accepted. Both require the unit to be in a nonzero mode first. The stimulus therefore walks every ordered pair of modes: it writes the first mode through normal operation and then writes the second mode directly, with clear pulses placed on some of the illegal writes. Carrier and collision are toggled while each mode is held, so the two-cycle synchronizer delay and the masking for each mode are both observed.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

   typedef enum logic [1:0] {
      LB_OFF  = 2'b00,
      LB_INT  = 2'b01,
      LB_EXT  = 2'b10,
      LB_LINE = 2'b11
   } lb_mode_e;

   typedef struct packed {
      logic crs;
      logic col;
   } carrier_t;

   localparam int CARRIER_W = $bits(carrier_t);

   // A move is allowed when it starts or ends in normal operation or keeps the mode.
   function automatic logic lb_move_ok(input lb_mode_e cur, input lb_mode_e nxt);
      return (cur == LB_OFF) || (nxt == LB_OFF) || (cur == nxt);
   endfunction

endpackage

// File: rtl/lbk_sync.sv
module lbk_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   localparam int LAST = STAGES - 1;

   logic [WIDTH-1:0] pipe [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lbk_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("lbk_sync: WIDTH must be positive");
      end

      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[i] <= '0;
               else        pipe[i] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[i] <= '0;
               else        pipe[i] <= pipe[i-1];
            end
         end
      end
   endgenerate

   assign q = pipe[LAST];

endmodule

// File: rtl/lbk_mode_reg.sv
module lbk_mode_reg
   import lbk_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  lb_mode_e wr_mode,
   input  logic     wr_crc,
   input  logic     err_clr,
   output lb_mode_e mode,
   output logic     crc_on,
   output logic     mode_err
);

   logic move_ok;
   logic accept;
   logic reject;

   always_comb begin
      move_ok = lb_move_ok(mode, wr_mode);
      accept  = wr_en && move_ok;
      reject  = wr_en && !move_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= LB_OFF;
         crc_on <= 1'b0;
      end else if (accept) begin
         mode   <= wr_mode;
         crc_on <= wr_crc;
      end
   end

   // A rejected write wins over a clear arriving in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_err <= 1'b0;
      else if (reject)  mode_err <= 1'b1;
      else if (err_clr) mode_err <= 1'b0;
   end

   a_r8_illegal_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode != LB_OFF && wr_mode != LB_OFF && wr_mode != mode)
         |=> (mode == $past(mode)) && (crc_on == $past(crc_on)));

   a_r8_illegal_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode != LB_OFF && wr_mode != LB_OFF && wr_mode != mode) |=> mode_err);

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_err && !err_clr) |=> mode_err);

   a_r10_no_direct_hop: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) != LB_OFF && mode != LB_OFF) |-> (mode == $past(mode)));

endmodule

// File: rtl/lbk_path_mux.sv
module lbk_path_mux
   import lbk_pkg::*;
#(
   parameter int DATA_W = 1
) (
   input  lb_mode_e          mode,
   input  logic [DATA_W-1:0] ser_tx_data,
   input  logic              tx_clk_in,
   input  logic [DATA_W-1:0] line_rx_data,
   input  logic              line_rx_clk,
   output logic [DATA_W-1:0] line_tx_data,
   output logic [DATA_W-1:0] deser_rx_data,
   output logic              deser_rx_clk,
   output logic              phy_loop_force
);

   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("lbk_path_mux: DATA_W must be positive");
      end
   endgenerate

   always_comb begin
      line_tx_data   = ser_tx_data;
      deser_rx_data  = line_rx_data;
      deser_rx_clk   = line_rx_clk;
      phy_loop_force = 1'b0;
      unique case (mode)
         LB_INT: begin
            line_tx_data  = '0;
            deser_rx_data = ser_tx_data;
            deser_rx_clk  = tx_clk_in;
         end
         LB_EXT:  phy_loop_force = 1'b1;
         LB_LINE: ;
         default: ;
      endcase
   end

endmodule

// File: rtl/lbk_status_mask.sv
module lbk_status_mask
   import lbk_pkg::*;
#(
   parameter bit REG_STATUS = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  lb_mode_e mode,
   input  carrier_t sync_in,
   output logic     status_crs,
   output logic     status_col
);

   carrier_t masked;

   always_comb begin
      masked = sync_in;
      unique case (mode)
         LB_INT: begin
            masked.crs = 1'b0;
            masked.col = 1'b0;
         end
         LB_EXT:  masked.col = 1'b0;
         default: ;
      endcase
   end

   generate
      if (REG_STATUS) begin : g_reg
         carrier_t held;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held <= '0;
            else        held <= masked;
         end
         assign status_crs = held.crs;
         assign status_col = held.col;
      end else begin : g_comb
         assign status_crs = masked.crs;
         assign status_col = masked.col;
      end
   endgenerate

endmodule

// File: rtl/lbk_ctrl.sv
module lbk_ctrl
   import lbk_pkg::*;
#(
   parameter int DATA_W      = 1,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_STATUS  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_loop_sel,
   input  logic              cfg_crc_chk,
   input  logic              err_clear,
   input  logic [DATA_W-1:0] ser_tx_data,
   input  logic              tx_clk_in,
   input  logic [DATA_W-1:0] line_rx_data,
   input  logic              line_rx_clk,
   input  logic              crs_raw,
   input  logic              col_raw,
   output logic [1:0]        lb_mode,
   output logic              phy_loop_force,
   output logic [DATA_W-1:0] line_tx_data,
   output logic [DATA_W-1:0] deser_rx_data,
   output logic              deser_rx_clk,
   output logic              status_crs,
   output logic              status_col,
   output logic              defer_crs,
   output logic              defer_col,
   output logic              rx_addr_chk_en,
   output logic              rx_crc_chk_en,
   output logic              mode_err
);

   lb_mode_e mode_q;
   logic     crc_q;
   carrier_t raw_c;
   carrier_t sync_c;

   lbk_mode_reg u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr),
      .wr_mode  (lb_mode_e'(cfg_loop_sel)),
      .wr_crc   (cfg_crc_chk),
      .err_clr  (err_clear),
      .mode     (mode_q),
      .crc_on   (crc_q),
      .mode_err (mode_err)
   );

   assign raw_c.crs = crs_raw;
   assign raw_c.col = col_raw;

   lbk_sync #(
      .WIDTH  (CARRIER_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_c),
      .q     (sync_c)
   );

   lbk_path_mux #(
      .DATA_W (DATA_W)
   ) u_path (
      .mode           (mode_q),
      .ser_tx_data    (ser_tx_data),
      .tx_clk_in      (tx_clk_in),
      .line_rx_data   (line_rx_data),
      .line_rx_clk    (line_rx_clk),
      .line_tx_data   (line_tx_data),
      .deser_rx_data  (deser_rx_data),
      .deser_rx_clk   (deser_rx_clk),
      .phy_loop_force (phy_loop_force)
   );

   lbk_status_mask #(
      .REG_STATUS (REG_STATUS)
   ) u_mask (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode_q),
      .sync_in    (sync_c),
      .status_crs (status_crs),
      .status_col (status_col)
   );

   assign lb_mode        = mode_q;
   assign defer_crs      = sync_c.crs;
   assign defer_col      = sync_c.col;
   assign rx_addr_chk_en = (mode_q != LB_OFF);
   assign rx_crc_chk_en  = (mode_q != LB_OFF) && crc_q;

   a_r2_internal_path: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == LB_INT) |-> (deser_rx_data == ser_tx_data) && (line_tx_data == '0));

   a_r3_force_only_ext: assert property (@(posedge clk) disable iff (!rst_n)
      phy_loop_force |-> (lb_mode == 2'b10) && (line_tx_data == ser_tx_data));

   a_r5_internal_hides: assert property (@(posedge clk) disable iff (!rst_n)
      (lb_mode == 2'b01) |-> !status_crs && !status_col);

   a_r6_ext_masks_col: assert property (@(posedge clk) disable iff (!rst_n)
      phy_loop_force |-> !status_col);

   a_r11_crc_needs_loop: assert property (@(posedge clk) disable iff (!rst_n)
      rx_crc_chk_en |-> rx_addr_chk_en);

endmodule

// File: tb/lbk_ctrl_test.sv
module lbk_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [1:0] cfg_loop_sel = 2'b00;
   logic       cfg_crc_chk = 1'b0;
   logic       err_clear = 1'b0;
   logic [0:0] ser_tx_data = 1'b0;
   logic       tx_clk_in = 1'b0;
   logic [0:0] line_rx_data = 1'b0;
   logic       line_rx_clk = 1'b0;
   logic       crs_raw = 1'b0;
   logic       col_raw = 1'b0;
   logic [1:0] lb_mode;
   logic       phy_loop_force;
   logic [0:0] line_tx_data;
   logic [0:0] deser_rx_data;
   logic       deser_rx_clk;
   logic       status_crs, status_col, defer_crs, defer_col;
   logic       rx_addr_chk_en, rx_crc_chk_en, mode_err;

   always #4 clk = ~clk;

   lbk_ctrl #(.DATA_W(1), .SYNC_STAGES(2), .REG_STATUS(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_loop_sel(cfg_loop_sel),
      .cfg_crc_chk(cfg_crc_chk), .err_clear(err_clear), .ser_tx_data(ser_tx_data),
      .tx_clk_in(tx_clk_in), .line_rx_data(line_rx_data), .line_rx_clk(line_rx_clk),
      .crs_raw(crs_raw), .col_raw(col_raw), .lb_mode(lb_mode),
      .phy_loop_force(phy_loop_force), .line_tx_data(line_tx_data),
      .deser_rx_data(deser_rx_data), .deser_rx_clk(deser_rx_clk),
      .status_crs(status_crs), .status_col(status_col), .defer_crs(defer_crs),
      .defer_col(defer_col), .rx_addr_chk_en(rx_addr_chk_en),
      .rx_crc_chk_en(rx_crc_chk_en), .mode_err(mode_err)
   );

   typedef struct {
      logic [1:0] mode;
      logic err, phy, ltx, dsd, dsc, scrs, scol, dcrs, dcol, addr, crcc;
      string tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state, built from the requirements
   logic [1:0] m_mode = 2'b00;
   logic m_crc = 0, m_err = 0;
   logic s1_crs = 0, s1_col = 0, s2_crs = 0, s2_col = 0;

   task automatic chk(input string req, input string name, input logic [1:0] act,
                      input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
      end
   endtask

   // driver: apply one cycle of stimulus and queue the result expected after the edge
   task automatic step(input logic wr, input logic [1:0] sel, input logic crc,
                       input logic clr, input logic ser, input logic lrx,
                       input logic txc, input logic rxc, input logic crs,
                       input logic col, input string tag);
      exp_t e;
      logic legal;
      @(negedge clk);
      cfg_wr = wr; cfg_loop_sel = sel; cfg_crc_chk = crc; err_clear = clr;
      ser_tx_data = ser; line_rx_data = lrx; tx_clk_in = txc; line_rx_clk = rxc;
      crs_raw = crs; col_raw = col;
      legal = (m_mode == 2'b00) || (sel == 2'b00) || (sel == m_mode);
      m_err = (wr && !legal) | (m_err & ~clr);
      if (wr && legal) begin
         m_mode = sel;
         m_crc  = crc;
      end
      s2_crs = s1_crs; s2_col = s1_col;
      s1_crs = crs;    s1_col = col;
      e.mode = m_mode;
      e.err  = m_err;
      e.phy  = (m_mode == 2'b10);
      e.ltx  = (m_mode == 2'b01) ? 1'b0 : ser;
      e.dsd  = (m_mode == 2'b01) ? ser : lrx;
      e.dsc  = (m_mode == 2'b01) ? txc : rxc;
      e.scrs = (m_mode == 2'b01) ? 1'b0 : s2_crs;
      e.scol = (m_mode == 2'b01 || m_mode == 2'b10) ? 1'b0 : s2_col;
      e.dcrs = s2_crs;
      e.dcol = s2_col;
      e.addr = (m_mode != 2'b00);
      e.crcc = (m_mode != 2'b00) && m_crc;
      e.tag  = tag;
      q.push_back(e);
   endtask

   // monitor: compare outputs shortly after each rising edge
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(e.tag,  "lb_mode",        lb_mode,        e.mode);
         chk("R9",   "mode_err",       mode_err,       e.err);
         chk("R3",   "phy_loop_force", phy_loop_force, e.phy);
         chk("R4",   "line_tx_data",   line_tx_data,   e.ltx);
         chk("R2",   "deser_rx_data",  deser_rx_data,  e.dsd);
         chk("R2",   "deser_rx_clk",   deser_rx_clk,   e.dsc);
         chk("R5",   "status_crs",     status_crs,     e.scrs);
         chk("R6",   "status_col",     status_col,     e.scol);
         chk("R7",   "defer_crs",      defer_crs,      e.dcrs);
         chk("R7",   "defer_col",      defer_col,      e.dcol);
         chk("R11",  "rx_addr_chk_en", rx_addr_chk_en, e.addr);
         chk("R11",  "rx_crc_chk_en",  rx_crc_chk_en,  e.crcc);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "lb_mode",        lb_mode,        2'b00);
      chk("R1", "phy_loop_force", phy_loop_force, 1'b0);
      chk("R1", "mode_err",       mode_err,       1'b0);
      chk("R1", "rx_crc_chk_en",  rx_crc_chk_en,  1'b0);
      chk("R1", "defer_crs",      defer_crs,      1'b0);
      chk("R1", "status_col",     status_col,     1'b0);
      rst_n = 1'b1;

      // normal operation with carrier activity (R4, R6, R7)
      step(0, 2'b00, 0, 0, 1, 0, 1, 0, 1, 0, "R4");
      step(0, 2'b00, 0, 0, 0, 1, 0, 1, 1, 1, "R4");
      step(0, 2'b00, 0, 0, 1, 1, 1, 0, 0, 1, "R7");
      step(0, 2'b00, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
      // internal loopback with CRC check (R10, R2, R5, R11)
      step(1, 2'b01, 1, 0, 1, 0, 1, 0, 1, 1, "R10");
      step(0, 2'b01, 0, 0, 0, 1, 0, 1, 1, 1, "R2");
      step(0, 2'b01, 0, 0, 1, 0, 1, 0, 1, 1, "R5");
      // illegal hop, then clear (R8, R9)
      step(1, 2'b10, 0, 0, 0, 1, 0, 1, 0, 1, "R8");
      step(0, 2'b01, 0, 0, 1, 1, 1, 1, 0, 0, "R8");
      step(0, 2'b00, 0, 1, 0, 0, 0, 0, 0, 0, "R9");
      // illegal hop with clear in the same cycle: set wins (R9)
      step(1, 2'b11, 1, 1, 1, 0, 1, 0, 1, 1, "R8");
      step(0, 2'b00, 0, 1, 1, 0, 1, 0, 1, 1, "R9");
      // through normal into external-interface loopback (R3, R6)
      step(1, 2'b00, 0, 0, 0, 1, 0, 1, 1, 1, "R10");
      step(1, 2'b10, 0, 0, 1, 0, 1, 1, 1, 1, "R10");
      step(0, 2'b00, 0, 0, 0, 1, 0, 0, 1, 1, "R6");
      step(0, 2'b00, 0, 0, 1, 1, 1, 1, 0, 1, "R3");
      // same-mode rewrite is legal and updates the CRC bit (R10, R11)
      step(1, 2'b10, 1, 0, 0, 0, 0, 0, 1, 0, "R10");
      step(0, 2'b00, 0, 0, 1, 0, 0, 1, 1, 0, "R11");
      // line loopback (R4, R6)
      step(1, 2'b00, 0, 0, 0, 1, 1, 0, 0, 1, "R10");
      step(1, 2'b11, 0, 0, 1, 0, 0, 1, 1, 1, "R10");
      step(0, 2'b00, 0, 0, 0, 1, 1, 1, 1, 1, "R6");
      step(0, 2'b00, 0, 0, 1, 1, 0, 0, 0, 0, "R4");

      // every ordered pair of modes, reached through normal operation
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            step(1, 2'b00, 0, 1, a[0], b[0], a[1], b[1], 1, 0, "R10");
            step(1, 2'(a), a[0], 0, b[0], a[0], b[1], a[1], 1, 1, "R10");
            step(1, 2'(b), b[1], (a == 3), a[1], b[1], a[0], b[0], 0, 1,
                 (a != 0 && b != 0 && a != b) ? "R8" : "R10");
            step(0, 2'b00, 0, 0, b[0], a[0], b[0], a[1], 1, 1, "R5");
            step(0, 2'b00, 0, 0, a[0], b[1], a[1], b[0], 0, 0, "R6");
         end
      end

      @(negedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule